// File: doc/BRIEF.md
# Double-Buffered Deflection Control Register Bank

This block is the register side of a display deflection controller. It sits behind a serial-bus slave that presents each received byte as a parallel write: a sub-address, a data byte and a one-cycle acknowledge strobe. Two timing-sensitive values live here: a horizontal duty-cycle setting and a supply reference level. Each has its own apply-mode bit, carried in bit 7 of the byte that writes the value. When the bit is clear, the value becomes active at the acknowledge. When it is set, the value waits in a shadow buffer. It moves to the active output on the next vertical-retrace pulse, so the analog side never sees a mid-frame change.

A control byte holds two plain enables and a two-bit phase-locked-loop charge-pump strength. It also has a command bit that clears a small set of sticky sync-detection flags. The command bit is never stored: it acts once, at the acknowledge of the write that carries it. The flags are set by one-cycle pulses from the detection logic and hold until that command clears them.

Top module: `defl_ctrl_bank`

## Requirements
- R1: While reset is asserted and right after it, every active value, mode bit, control field and detection flag reads zero.
- R2: A write to sub-address 00h with bit 7 = 0 puts bits 6:0 on the duty-cycle output in the cycle after the acknowledge, and shows 0 on the duty apply-mode output.
- R3: A write to sub-address 00h with bit 7 = 1 sets the duty apply-mode output to 1 at the acknowledge. The duty-cycle output keeps its old value until the next vertical-retrace pulse, then takes the buffered bits 6:0.
- R4: Sub-address 03h gives the supply reference value the same choice through its own bit 7, independent of the duty-cycle setting.
- R5: If several deferred writes reach one parameter before a vertical pulse, only the last one is applied. An immediate write discards any pending deferred value.
- R6: A vertical pulse with no pending value leaves the active output unchanged. A deferred write acknowledged in the same cycle as a vertical pulse stays pending for the following pulse.
- R7: At sub-address 16h, bit 0 drives the lock-status output enable and bit 1 the loop-inhibit enable. Bits 3:2 drive the pump strength code (00 slowest, 01 moderate-slow, 10 moderate-fast, 11 fastest). All take effect at the acknowledge.
- R8: A one-cycle pulse on a flag-set input bit sets the matching detection flag, and the flag stays set without further pulses.
- R9: A write to 16h with bit 4 = 1 clears all detection flags at the acknowledge. A write with bit 4 = 0 leaves them as they are, and the command does not persist to later writes.
- R10: When a flag-set pulse and the clear command arrive in the same cycle, that flag ends up set.
- R11: Writes to any other sub-address change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ack | input | 1 | One-cycle strobe marking an acknowledged byte write |
| wr_addr | input | 8 | Sub-address of the write |
| wr_data | input | 8 | Data byte of the write |
| vert_evt | input | 1 | One-cycle vertical-retrace event pulse |
| flag_set | input | 3 | One-cycle set pulses for the detection flags |
| duty_val | output | 7 | Active horizontal duty-cycle value |
| duty_defer | output | 1 | Duty-cycle apply mode (1 = wait for vertical pulse) |
| supref_val | output | 7 | Active supply reference value |
| supref_defer | output | 1 | Supply reference apply mode (1 = wait for vertical pulse) |
| lock_out_en | output | 1 | Enable for routing lock status to its output |
| pll_inhibit_en | output | 1 | Enable for loop inhibit during vertical sync |
| pump_sel | output | 2 | Charge-pump strength code |
| det_flags | output | 3 | Sticky sync-detection flags |

## Verification
The bench uses the default parameters: 8-bit sub-addresses and data, 7-bit values, three flags, and the deferred variant of both value slots. With these values the whole apply-mode path can be reached. That covers the shadow buffer, the pending bit, last-write-wins, the cancelling of a pending value by an immediate write, and a write landing in the same cycle as a vertical pulse. With three flags, the test can clear several flags at once and then watch a single flag win a same-cycle set/clear race while the other two stay cleared.

// File: rtl/defl_ctrl_pkg.sv
package defl_ctrl_pkg;

   // Bit positions that the attached deflection logic decodes.
   localparam int unsigned MODE_BIT  = 7;
   localparam int unsigned LOCK_BIT  = 0;
   localparam int unsigned INH_BIT   = 1;
   localparam int unsigned PUMP_LSB  = 2;
   localparam int unsigned PUMP_W    = 2;
   localparam int unsigned CLR_BIT   = 4;
   localparam int unsigned MIN_DATA_W = MODE_BIT + 1;

   typedef enum logic [PUMP_W-1:0] {
      PUMP_SLOWEST  = 2'b00,
      PUMP_MOD_SLOW = 2'b01,
      PUMP_MOD_FAST = 2'b10,
      PUMP_FASTEST  = 2'b11
   } pump_e;

   typedef struct packed {
      logic  inhibit_en;
      logic  lock_en;
      pump_e pump;
   } ctrl_fields_t;

endpackage

// File: rtl/dbuf_slot.sv
module dbuf_slot #(
   parameter int unsigned VAL_W    = 7,
   parameter bit          DEFER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_defer,
   input  logic [VAL_W-1:0] load_val,
   input  logic             vert_evt,
   output logic [VAL_W-1:0] active_val,
   output logic             defer_mode
);

   if (VAL_W < 1) begin : g_bad_width
      $error("dbuf_slot: VAL_W must be at least 1");
   end

   // The apply-mode bit always follows the latest write at once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         defer_mode <= 1'b0;
      end else if (load) begin
         defer_mode <= load_defer;
      end
   end

   if (DEFER_EN) begin : g_deferred
      logic [VAL_W-1:0] shadow_q;
      logic             pending_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active_val <= '0;
            shadow_q   <= '0;
            pending_q  <= 1'b0;
         end else if (load && !load_defer) begin
            // Immediate write: applies now and drops any pending value.
            active_val <= load_val;
            shadow_q   <= load_val;
            pending_q  <= 1'b0;
         end else begin
            if (vert_evt && pending_q) begin
               active_val <= shadow_q;
               pending_q  <= 1'b0;
            end
            // A deferred write in the same cycle as the event stays pending.
            if (load) begin
               shadow_q  <= load_val;
               pending_q <= 1'b1;
            end
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active_val <= '0;
         end else if (load) begin
            active_val <= load_val;
         end
      end
   end

endmodule

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank #(
   parameter int unsigned NFLAGS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLAGS-1:0] set_pulse,
   input  logic              clear_all,
   output logic [NFLAGS-1:0] flags
);

   if (NFLAGS < 1) begin : g_bad_count
      $error("sticky_flag_bank: NFLAGS must be at least 1");
   end

   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
         end else if (set_pulse[i]) begin
            flags[i] <= 1'b1;        // set takes precedence over clear
         end else if (clear_all) begin
            flags[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ctrl_field_reg.sv
module ctrl_field_reg
   import defl_ctrl_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output ctrl_fields_t      fields,
   output logic              clear_cmd
);

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("ctrl_field_reg: DATA_W too small for the control byte layout");
   end

   ctrl_fields_t next_fields;

   always_comb begin
      next_fields.lock_en    = load_data[LOCK_BIT];
      next_fields.inhibit_en = load_data[INH_BIT];
      next_fields.pump       = pump_e'(load_data[PUMP_LSB +: PUMP_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields <= '{inhibit_en: 1'b0, lock_en: 1'b0, pump: PUMP_SLOWEST};
      end else if (load) begin
         fields <= next_fields;
      end
   end

   // The clear command is a pulse in the acknowledge cycle only; nothing stores it.
   assign clear_cmd = load && load_data[CLR_BIT];

endmodule

// File: rtl/defl_ctrl_bank.sv
module defl_ctrl_bank
   import defl_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned VAL_W       = 7,
   parameter int unsigned NFLAGS      = 3,
   parameter bit          DUTY_DEFER  = 1'b1,
   parameter bit          SUP_DEFER   = 1'b1,
   parameter logic [7:0]  ADDR_DUTY   = 8'h00,
   parameter logic [7:0]  ADDR_SUPREF = 8'h03,
   parameter logic [7:0]  ADDR_CTRL   = 8'h16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ack,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              vert_evt,
   input  logic [NFLAGS-1:0] flag_set,
   output logic [VAL_W-1:0]  duty_val,
   output logic              duty_defer,
   output logic [VAL_W-1:0]  supref_val,
   output logic              supref_defer,
   output logic              lock_out_en,
   output logic              pll_inhibit_en,
   output logic [1:0]        pump_sel,
   output logic [NFLAGS-1:0] det_flags
);

   localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADDR_DUTY);
   localparam logic [ADDR_W-1:0] A_SUP  = ADDR_W'(ADDR_SUPREF);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

   if (DATA_W < MIN_DATA_W) begin : g_bad_data
      $error("defl_ctrl_bank: DATA_W must hold the mode bit");
   end
   if (VAL_W > MODE_BIT) begin : g_bad_val
      $error("defl_ctrl_bank: VAL_W overlaps the mode bit");
   end
   if (A_DUTY == A_SUP || A_DUTY == A_CTRL || A_SUP == A_CTRL) begin : g_bad_addr
      $error("defl_ctrl_bank: sub-addresses must be distinct");
   end

   logic hit_duty, hit_sup, hit_ctrl, clear_cmd;
   ctrl_fields_t fields;

   always_comb begin
      hit_duty = wr_ack && (wr_addr == A_DUTY);
      hit_sup  = wr_ack && (wr_addr == A_SUP);
      hit_ctrl = wr_ack && (wr_addr == A_CTRL);
   end

   dbuf_slot #(.VAL_W(VAL_W), .DEFER_EN(DUTY_DEFER)) u_duty (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (hit_duty),
      .load_defer (wr_data[MODE_BIT]),
      .load_val   (wr_data[VAL_W-1:0]),
      .vert_evt   (vert_evt),
      .active_val (duty_val),
      .defer_mode (duty_defer)
   );

   dbuf_slot #(.VAL_W(VAL_W), .DEFER_EN(SUP_DEFER)) u_supref (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (hit_sup),
      .load_defer (wr_data[MODE_BIT]),
      .load_val   (wr_data[VAL_W-1:0]),
      .vert_evt   (vert_evt),
      .active_val (supref_val),
      .defer_mode (supref_defer)
   );

   ctrl_field_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (hit_ctrl),
      .load_data (wr_data),
      .fields    (fields),
      .clear_cmd (clear_cmd)
   );

   sticky_flag_bank #(.NFLAGS(NFLAGS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (flag_set),
      .clear_all (clear_cmd),
      .flags     (det_flags)
   );

   assign lock_out_en    = fields.lock_en;
   assign pll_inhibit_en = fields.inhibit_en;
   assign pump_sel       = fields.pump;

endmodule

// File: rtl/defl_ctrl_bank_chk.sv
module defl_ctrl_bank_chk #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned VAL_W       = 7,
   parameter int unsigned NFLAGS      = 3,
   parameter logic [7:0]  ADDR_DUTY   = 8'h00,
   parameter logic [7:0]  ADDR_SUPREF = 8'h03,
   parameter logic [7:0]  ADDR_CTRL   = 8'h16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_ack,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              vert_evt,
   input logic [NFLAGS-1:0] flag_set,
   input logic [VAL_W-1:0]  duty_val,
   input logic              duty_defer,
   input logic [VAL_W-1:0]  supref_val,
   input logic              supref_defer,
   input logic              lock_out_en,
   input logic              pll_inhibit_en,
   input logic [1:0]        pump_sel,
   input logic [NFLAGS-1:0] det_flags
);

   localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(ADDR_DUTY);
   localparam logic [ADDR_W-1:0] A_SUP  = ADDR_W'(ADDR_SUPREF);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

   logic w_duty, w_sup, w_ctrl, w_other;
   assign w_duty  = wr_ack && wr_addr == A_DUTY;
   assign w_sup   = wr_ack && wr_addr == A_SUP;
   assign w_ctrl  = wr_ack && wr_addr == A_CTRL;
   assign w_other = wr_ack && !(w_duty || w_sup || w_ctrl);

   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |=> (duty_val == '0 && supref_val == '0 && det_flags == '0 && pump_sel == 2'b00));

   assert_async_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (w_duty && !wr_data[7]) |=> (duty_val == $past(wr_data[VAL_W-1:0]) && !duty_defer));

   assert_defer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (w_duty && wr_data[7] && !vert_evt) |=> ($stable(duty_val) && duty_defer));

   assert_async_supref_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (w_sup && !wr_data[7]) |=> (supref_val == $past(wr_data[VAL_W-1:0])));

   assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_sup && !vert_evt) |=> $stable(supref_val));

   assert_ctrl_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      w_ctrl |=> (pump_sel == $past(wr_data[3:2]) && lock_out_en == $past(wr_data[0])));

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_ctrl) |=> ((det_flags & $past(det_flags | flag_set)) == $past(det_flags | flag_set)));

   assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctrl && wr_data[4]) |=> (det_flags == $past(flag_set)));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_set) |=> ((det_flags & $past(flag_set)) == $past(flag_set)));

   assert_ignore_other_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (w_other && !vert_evt) |=> ($stable(duty_val) && $stable(supref_val) && $stable(pump_sel)));

endmodule

bind defl_ctrl_bank defl_ctrl_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .NFLAGS(NFLAGS),
   .ADDR_DUTY(ADDR_DUTY), .ADDR_SUPREF(ADDR_SUPREF), .ADDR_CTRL(ADDR_CTRL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
   .vert_evt(vert_evt), .flag_set(flag_set), .duty_val(duty_val), .duty_defer(duty_defer),
   .supref_val(supref_val), .supref_defer(supref_defer), .lock_out_en(lock_out_en),
   .pll_inhibit_en(pll_inhibit_en), .pump_sel(pump_sel), .det_flags(det_flags)
);

// File: tb/tb_defl_ctrl_bank.sv
module tb_defl_ctrl_bank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_ack = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       vert_evt = 1'b0;
   logic [2:0] flag_set = '0;
   logic [6:0] duty_val, supref_val;
   logic       duty_defer, supref_defer, lock_out_en, pll_inhibit_en;
   logic [1:0] pump_sel;
   logic [2:0] det_flags;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   defl_ctrl_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
      .vert_evt(vert_evt), .flag_set(flag_set), .duty_val(duty_val), .duty_defer(duty_defer),
      .supref_val(supref_val), .supref_defer(supref_defer), .lock_out_en(lock_out_en),
      .pll_inhibit_en(pll_inhibit_en), .pump_sel(pump_sel), .det_flags(det_flags)
   );

   // Vector: {op[1:0], addr[7:0], data[7:0], duty_mode, duty[6:0], sup_mode, sup[6:0]}
   // op 0 = write only, 1 = vertical pulse only, 2 = write and vertical pulse together
   localparam int NVEC = 15;
   localparam logic [33:0] VEC [NVEC] = '{
      {2'd0, 8'h00, 8'h15, 1'b0, 7'h15, 1'b0, 7'h00},
      {2'd0, 8'h03, 8'h22, 1'b0, 7'h15, 1'b0, 7'h22},
      {2'd0, 8'h00, 8'hC0, 1'b1, 7'h15, 1'b0, 7'h22},
      {2'd0, 8'h00, 8'hC5, 1'b1, 7'h15, 1'b0, 7'h22},
      {2'd1, 8'h00, 8'h00, 1'b1, 7'h45, 1'b0, 7'h22},
      {2'd1, 8'h00, 8'h00, 1'b1, 7'h45, 1'b0, 7'h22},
      {2'd0, 8'h03, 8'h81, 1'b1, 7'h45, 1'b1, 7'h22},
      {2'd1, 8'h00, 8'h00, 1'b1, 7'h45, 1'b1, 7'h01},
      {2'd0, 8'h00, 8'h8A, 1'b1, 7'h45, 1'b1, 7'h01},
      {2'd0, 8'h00, 8'h0B, 1'b0, 7'h0B, 1'b1, 7'h01},
      {2'd1, 8'h00, 8'h00, 1'b0, 7'h0B, 1'b1, 7'h01},
      {2'd0, 8'h05, 8'h7F, 1'b0, 7'h0B, 1'b1, 7'h01},
      {2'd2, 8'h00, 8'h93, 1'b1, 7'h0B, 1'b1, 7'h01},
      {2'd1, 8'h00, 8'h00, 1'b1, 7'h13, 1'b1, 7'h01},
      {2'd0, 8'h03, 8'h7F, 1'b1, 7'h13, 1'b0, 7'h7F}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0:        return "R2";
         1, 14:    return "R4";
         2, 3:     return "R3";
         4, 8, 9:  return "R5";
         5, 10:    return "R6";
         6, 7:     return "R4";
         11:       return "R11";
         default:  return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge capture, return at the next falling edge.
   task automatic step(input logic ack, input logic [7:0] a, input logic [7:0] d,
                       input logic v, input logic [2:0] fs);
      wr_ack = ack; wr_addr = a; wr_data = d; vert_evt = v; flag_set = fs;
      @(negedge clk);
      wr_ack = 1'b0; vert_evt = 1'b0; flag_set = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", {duty_val, supref_val, duty_defer, supref_defer, lock_out_en,
            pll_inhibit_en, pump_sel, det_flags}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [33:0] v;
         v = VEC[i];
         step(v[33:32] != 2'd1, v[31:24], v[23:16], v[33:32] != 2'd0, 3'b000);
         check($sformatf("%s vec%0d", vec_tag(i), i),
               {16'h0, duty_defer, duty_val, supref_defer, supref_val}, {16'h0, v[15:0]});
      end

      // R7: control byte fields
      step(1'b1, 8'h16, 8'h0D, 1'b0, 3'b000);
      check("R7 ctrl 0D", {lock_out_en, pll_inhibit_en, pump_sel}, {1'b1, 1'b0, 2'b11});
      step(1'b1, 8'h16, 8'h06, 1'b0, 3'b000);
      check("R7 ctrl 06", {lock_out_en, pll_inhibit_en, pump_sel}, {1'b0, 1'b1, 2'b01});

      // R8: sticky set
      step(1'b0, 8'h00, 8'h00, 1'b0, 3'b001);
      step(1'b0, 8'h00, 8'h00, 1'b0, 3'b100);
      @(negedge clk);
      check("R8 sticky", det_flags, 3'b101);

      // R9: bit 4 = 0 keeps flags
      step(1'b1, 8'h16, 8'h0A, 1'b0, 3'b000);
      check("R9 no clear", det_flags, 3'b101);
      check("R7 ctrl 0A", {lock_out_en, pll_inhibit_en, pump_sel}, {1'b0, 1'b1, 2'b10});
      // R9: bit 4 = 1 clears at acknowledge, then not persistent
      step(1'b1, 8'h16, 8'h16, 1'b0, 3'b000);
      check("R9 clear", det_flags, 3'b000);
      step(1'b0, 8'h00, 8'h00, 1'b0, 3'b010);
      step(1'b1, 8'h16, 8'h02, 1'b0, 3'b000);
      check("R9 not stored", det_flags, 3'b010);

      // R10: set and clear in the same cycle
      step(1'b0, 8'h00, 8'h00, 1'b0, 3'b001);
      step(1'b1, 8'h16, 8'h10, 1'b0, 3'b100);
      check("R10 set wins", det_flags, 3'b100);
      check("R7 ctrl 10", {lock_out_en, pll_inhibit_en, pump_sel}, 4'b0000);

      // R11: undefined sub-address leaves control and flags
      step(1'b1, 8'h17, 8'hFF, 1'b0, 3'b000);
      check("R11 ctrl/flags", {lock_out_en, pll_inhibit_en, pump_sel, det_flags}, 7'b0000_100);

      // R1: reset mid-run clears everything
      step(1'b1, 8'h00, 8'h2A, 1'b0, 3'b011);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset", {duty_val, supref_val, duty_defer, supref_defer, det_flags}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {duty_val, det_flags}, 32'h0);

      finish_run();
   end

endmodule